// File: doc/BRIEF.md
# Variable-Segment Compressed Set Manager

This block keeps the tag state of one set in a compressed cache. The set has twice as many tag slots as it has room for uncompressed lines. Its data area is a pool of 8-byte segments. Each line uses a variable number of segments: 8 when stored uncompressed, and 1 to 8 when compressed. Tags are therefore decoupled from data. A tag can stay valid after its data has been pushed out, so a later access can still tell that the line would have fitted had more lines been compressed.

Every request is either a lookup or a fill, and the answer comes back one cycle later. On a fill, the block does the following:

- It chooses a tag slot and records the line's compression status, size and permissions.
- It makes the new line most recently used.
- It then drops the data of the least recently used resident lines, one at a time, until the resident lines fit in the segment budget. Dropped lines keep their tags.

A lookup reports:

- whether the tag is present;
- whether its data is resident;
- its position in the recency stack;
- the stored size, compression bit and permission bits.

Top module: `cseg_set_mgr`

## Requirements
- R1: After reset all tag slots are empty. A lookup of any tag reports tag_hit=0, data_hit=0, stack position 0, size 0, compressed 0 and perm 0. rsp_valid is 0 until the first request.
- R2: rsp_valid is 1 in the cycle after a cycle with req_valid=1, and 0 in the cycle after a cycle with req_valid=0.
- R3: Every response describes the set as it was before the request. The fields are: tag_hit (a valid slot holds req_tag), data_hit (that slot's data is resident), rsp_stack_pos (1 = most recently used up to NUM_TAGS = least; 0 when tag_hit=0), and the stored size, compressed bit and perm bits (all 0 when tag_hit=0).
- R4: A tag whose data has been dropped stays valid. A lookup of it reports tag_hit=1 and data_hit=0, and leaves the recency order unchanged.
- R5: After every fill, the sum of the sizes of the resident lines is at most SEG_BUDGET (16). Lines are dropped starting from the least recently used resident line. The newly filled line is never dropped.
- R6: A fill (req_fill=1) makes the line valid, resident and most recently used. With req_compressed=0 it stores size 8 and compressed=0. With req_compressed=1 it stores req_size when that is 1 to 8, and 8 when req_size is 0 or above 8. req_perm is stored as given.
- R7: A fill whose tag is already valid reuses that slot. Otherwise it takes the lowest-numbered empty slot. When all slots are valid it replaces the tag at the least recently used stack position.
- R8: A lookup with data_hit=1 moves that line to the most recently used position. Lines that were more recent than it each move down by one, and the rest keep their positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_fill | input | 1 | 1 = fill, 0 = lookup |
| req_tag | input | 16 | Address tag of the request |
| req_compressed | input | 1 | Fill: line is stored compressed |
| req_size | input | 4 | Fill: compressed size in segments |
| req_perm | input | 2 | Fill: permission bits |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_tag_hit | output | 1 | Tag was present |
| rsp_data_hit | output | 1 | Tag was present with data resident |
| rsp_stack_pos | output | 3 | Recency position, 1 = most recent, 0 = absent |
| rsp_compressed | output | 1 | Stored compression bit |
| rsp_size | output | 4 | Stored size in segments |
| rsp_perm | output | 2 | Stored permission bits |

## Verification
The bench uses the default build: 4 tag slots over a 16-segment budget, with 8-segment uncompressed lines. With these values, four resident lines can exceed the budget, so the tag-without-data state, the drop order and replacement of the least recently used tag all occur within a few fills. Random sizes from 0 to 8 over a pool of seven tags also hit the size-0 substitution and the refill of an existing tag.

// File: rtl/cseg_pkg.sv
package cseg_pkg;
  localparam int CSEG_TAG_W  = 16;
  localparam int CSEG_PERM_W = 2;
  localparam int LINE_SEGS   = 8;
  localparam int CSEG_SIZE_W = $clog2(LINE_SEGS + 1);

  typedef struct packed {
    logic                   valid;
    logic                   resident;
    logic                   comp;
    logic [CSEG_SIZE_W-1:0] size;
    logic [CSEG_PERM_W-1:0] perm;
    logic [CSEG_TAG_W-1:0]  tag;
  } cseg_entry_t;
endpackage

// File: rtl/cseg_lru_stack.sv
module cseg_lru_stack #(
  parameter int NUM_TAGS = 4,
  localparam int IDX_W = $clog2(NUM_TAGS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               touch_en,
  input  logic [IDX_W-1:0]                   touch_way,
  output logic [NUM_TAGS-1:0][IDX_W-1:0]     stack_o,
  output logic [NUM_TAGS-1:0][IDX_W-1:0]     stack_next_o,
  output logic [IDX_W-1:0]                   lru_way_o
);
  logic [NUM_TAGS-1:0][IDX_W-1:0] stack_q, stack_d;
  int tpos;

  // position of the touched way in the current order
  always_comb begin
    tpos = NUM_TAGS - 1;
    for (int i = 0; i < NUM_TAGS; i++)
      if (stack_q[i] == touch_way) tpos = i;
  end

  always_comb begin
    stack_d[0] = touch_en ? touch_way : stack_q[0];
    for (int i = 1; i < NUM_TAGS; i++)
      stack_d[i] = (touch_en && i <= tpos) ? stack_q[i-1] : stack_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TAGS; i++) stack_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      stack_q <= stack_d;
    end
  end

  assign stack_o      = stack_q;
  assign stack_next_o = stack_d;
  assign lru_way_o    = stack_q[NUM_TAGS-1];

  // every way appears exactly once in the order
  logic perm_ok;
  always_comb begin
    perm_ok = 1'b1;
    for (int w = 0; w < NUM_TAGS; w++) begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < NUM_TAGS; i++)
        if (stack_q[i] == IDX_W'(w)) cnt++;
      if (cnt != 1) perm_ok = 1'b0;
    end
  end

  a_r8_order_is_permutation: assert property (@(posedge clk) disable iff (!rst_n) perm_ok);
  a_r8_touched_becomes_mru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> stack_q[0] == $past(touch_way));
endmodule

// File: rtl/cseg_tag_match.sv
module cseg_tag_match #(
  parameter int NUM_TAGS = 4,
  parameter int TAG_W    = 16,
  localparam int IDX_W = $clog2(NUM_TAGS),
  localparam int POS_W = $clog2(NUM_TAGS + 1)
) (
  input  logic [NUM_TAGS-1:0]              valid_i,
  input  logic [NUM_TAGS-1:0][TAG_W-1:0]   tags_i,
  input  logic [NUM_TAGS-1:0][IDX_W-1:0]   stack_i,
  input  logic [TAG_W-1:0]                 look_tag_i,
  output logic                             hit_o,
  output logic [IDX_W-1:0]                 hit_way_o,
  output logic [POS_W-1:0]                 hit_pos_o,
  output logic                             free_o,
  output logic [IDX_W-1:0]                 free_way_o
);
  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int i = 0; i < NUM_TAGS; i++)
      if (valid_i[i] && tags_i[i] == look_tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = IDX_W'(i);
      end
  end

  always_comb begin
    hit_pos_o = '0;
    if (hit_o)
      for (int p = 0; p < NUM_TAGS; p++)
        if (stack_i[p] == hit_way_o) hit_pos_o = POS_W'(p + 1);
  end

  // lowest-numbered empty slot
  always_comb begin
    free_o     = 1'b0;
    free_way_o = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--)
      if (!valid_i[i]) begin
        free_o     = 1'b1;
        free_way_o = IDX_W'(i);
      end
  end
endmodule

// File: rtl/cseg_evict.sv
module cseg_evict #(
  parameter int NUM_TAGS   = 4,
  parameter int SEG_BUDGET = 16,
  parameter int SIZE_W     = 4,
  localparam int IDX_W = $clog2(NUM_TAGS)
) (
  input  logic [NUM_TAGS-1:0]              res_i,
  input  logic [NUM_TAGS-1:0][SIZE_W-1:0]  size_i,
  input  logic [NUM_TAGS-1:0][IDX_W-1:0]   stack_i,
  output logic [NUM_TAGS-1:0]              res_o
);
  int total;

  // walk from the least recent end, shedding data until the pool fits
  always_comb begin
    total = 0;
    for (int i = 0; i < NUM_TAGS; i++)
      if (res_i[i]) total = total + int'(size_i[i]);
    res_o = res_i;
    for (int p = NUM_TAGS - 1; p >= 0; p--) begin
      if (res_o[stack_i[p]] && total > SEG_BUDGET) begin
        res_o[stack_i[p]] = 1'b0;
        total = total - int'(size_i[stack_i[p]]);
      end
    end
  end
endmodule

// File: rtl/cseg_set_mgr.sv
module cseg_set_mgr
  import cseg_pkg::*;
#(
  parameter int NUM_TAGS   = 4,
  parameter int SEG_BUDGET = 16,
  localparam int IDX_W = $clog2(NUM_TAGS),
  localparam int POS_W = $clog2(NUM_TAGS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_fill,
  input  logic [CSEG_TAG_W-1:0]   req_tag,
  input  logic                    req_compressed,
  input  logic [CSEG_SIZE_W-1:0]  req_size,
  input  logic [CSEG_PERM_W-1:0]  req_perm,
  output logic                    rsp_valid,
  output logic                    rsp_tag_hit,
  output logic                    rsp_data_hit,
  output logic [POS_W-1:0]        rsp_stack_pos,
  output logic                    rsp_compressed,
  output logic [CSEG_SIZE_W-1:0]  rsp_size,
  output logic [CSEG_PERM_W-1:0]  rsp_perm
);
  cseg_entry_t [NUM_TAGS-1:0] ent_q, ent_mid, ent_d;

  logic [NUM_TAGS-1:0]                   valid_v, res_mid, res_post;
  logic [NUM_TAGS-1:0][CSEG_TAG_W-1:0]   tag_v;
  logic [NUM_TAGS-1:0][CSEG_SIZE_W-1:0]  size_mid;
  logic [NUM_TAGS-1:0][IDX_W-1:0]        stack, stack_next;
  logic [IDX_W-1:0] lru_way, hit_way, free_way, fill_way, touch_way;
  logic [POS_W-1:0] hit_pos;
  logic hit, free, touch_en, do_fill, data_hit;
  logic [CSEG_SIZE_W-1:0] fill_size;

  always_comb begin
    for (int i = 0; i < NUM_TAGS; i++) begin
      valid_v[i] = ent_q[i].valid;
      tag_v[i]   = ent_q[i].tag;
    end
  end

  cseg_tag_match #(.NUM_TAGS(NUM_TAGS), .TAG_W(CSEG_TAG_W)) match_i (
    .valid_i(valid_v), .tags_i(tag_v), .stack_i(stack), .look_tag_i(req_tag),
    .hit_o(hit), .hit_way_o(hit_way), .hit_pos_o(hit_pos),
    .free_o(free), .free_way_o(free_way)
  );

  assign do_fill   = req_valid && req_fill;
  assign data_hit  = hit && ent_q[hit_way].resident;
  assign fill_way  = hit ? hit_way : (free ? free_way : lru_way);
  assign fill_size = (!req_compressed || req_size == '0 || int'(req_size) > LINE_SEGS)
                     ? CSEG_SIZE_W'(LINE_SEGS) : req_size;
  assign touch_en  = do_fill || (req_valid && !req_fill && data_hit);
  assign touch_way = do_fill ? fill_way : hit_way;

  cseg_lru_stack #(.NUM_TAGS(NUM_TAGS)) lru_i (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_way(touch_way),
    .stack_o(stack), .stack_next_o(stack_next), .lru_way_o(lru_way)
  );

  // next state before the budget is enforced
  always_comb begin
    ent_mid = ent_q;
    if (do_fill) begin
      ent_mid[fill_way].valid    = 1'b1;
      ent_mid[fill_way].resident = 1'b1;
      ent_mid[fill_way].comp     = req_compressed;
      ent_mid[fill_way].size     = fill_size;
      ent_mid[fill_way].perm     = req_perm;
      ent_mid[fill_way].tag      = req_tag;
    end
    for (int i = 0; i < NUM_TAGS; i++) begin
      res_mid[i]  = ent_mid[i].resident;
      size_mid[i] = ent_mid[i].size;
    end
  end

  cseg_evict #(.NUM_TAGS(NUM_TAGS), .SEG_BUDGET(SEG_BUDGET), .SIZE_W(CSEG_SIZE_W)) evict_i (
    .res_i(res_mid), .size_i(size_mid), .stack_i(stack_next), .res_o(res_post)
  );

  always_comb begin
    ent_d = ent_mid;
    if (do_fill)
      for (int i = 0; i < NUM_TAGS; i++) ent_d[i].resident = res_post[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (do_fill) begin
      ent_q <= ent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_tag_hit    <= 1'b0;
      rsp_data_hit   <= 1'b0;
      rsp_stack_pos  <= '0;
      rsp_compressed <= 1'b0;
      rsp_size       <= '0;
      rsp_perm       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_tag_hit    <= hit;
        rsp_data_hit   <= data_hit;
        rsp_stack_pos  <= hit_pos;
        rsp_compressed <= hit ? ent_q[hit_way].comp : 1'b0;
        rsp_size       <= hit ? ent_q[hit_way].size : '0;
        rsp_perm       <= hit ? ent_q[hit_way].perm : '0;
      end
    end
  end

  // checks on stored state
  int res_total;
  logic res_has_tag;
  always_comb begin
    res_total   = 0;
    res_has_tag = 1'b1;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (ent_q[i].resident) res_total = res_total + int'(ent_q[i].size);
      if (ent_q[i].resident && !ent_q[i].valid) res_has_tag = 1'b0;
    end
  end

  a_r5_budget_held: assert property (@(posedge clk) disable iff (!rst_n) res_total <= SEG_BUDGET);
  a_r4_data_needs_tag: assert property (@(posedge clk) disable iff (!rst_n) res_has_tag);
  a_r6_fill_resident: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> ent_q[$past(fill_way)].resident && ent_q[$past(fill_way)].valid);
  a_r3_pos_when_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tag_hit) |-> (rsp_stack_pos != '0 && int'(rsp_stack_pos) <= NUM_TAGS));
  a_r3_absent_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_tag_hit) |-> (rsp_stack_pos == '0 && !rsp_data_hit && rsp_size == '0));
endmodule

// File: tb/cseg_set_mgr_tb.sv
`timescale 1ns/1ps
module cseg_set_mgr_tb_top;
  localparam int NT = 4;
  localparam int BUDGET = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_fill = 1'b0, req_compressed = 1'b0;
  logic [15:0] req_tag = '0;
  logic [3:0] req_size = '0;
  logic [1:0] req_perm = '0;
  logic rsp_valid, rsp_tag_hit, rsp_data_hit, rsp_compressed;
  logic [2:0] rsp_stack_pos;
  logic [3:0] rsp_size;
  logic [1:0] rsp_perm;

  always #2 clk = ~clk;

  cseg_set_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fill(req_fill),
    .req_tag(req_tag), .req_compressed(req_compressed), .req_size(req_size),
    .req_perm(req_perm), .rsp_valid(rsp_valid), .rsp_tag_hit(rsp_tag_hit),
    .rsp_data_hit(rsp_data_hit), .rsp_stack_pos(rsp_stack_pos),
    .rsp_compressed(rsp_compressed), .rsp_size(rsp_size), .rsp_perm(rsp_perm)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // reference state
  bit m_valid[NT], m_res[NT], m_comp[NT];
  int m_size[NT], m_perm[NT], m_tag[NT], m_stack[NT];

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int find_way(int tag);
    for (int i = 0; i < NT; i++) if (m_valid[i] && m_tag[i] == tag) return i;
    return -1;
  endfunction

  function automatic int pos_of(int w);
    for (int p = 0; p < NT; p++) if (m_stack[p] == w) return p + 1;
    return 0;
  endfunction

  task automatic promote(int w);
    int p;
    p = pos_of(w) - 1;
    for (int i = p; i > 0; i--) m_stack[i] = m_stack[i-1];
    m_stack[0] = w;
  endtask

  task automatic model_fill(int tag, bit comp, int size, int perm);
    int w, total;
    w = find_way(tag);
    if (w < 0) begin
      for (int i = NT - 1; i >= 0; i--) if (!m_valid[i]) w = i;
      if (w < 0) w = m_stack[NT-1];
    end
    m_valid[w] = 1; m_res[w] = 1; m_comp[w] = comp; m_tag[w] = tag; m_perm[w] = perm;
    m_size[w] = (!comp || size == 0 || size > 8) ? 8 : size;
    promote(w);
    total = 0;
    for (int i = 0; i < NT; i++) if (m_res[i]) total += m_size[i];
    for (int p = NT - 1; p >= 0; p--)
      if (m_res[m_stack[p]] && total > BUDGET) begin
        m_res[m_stack[p]] = 0;
        total -= m_size[m_stack[p]];
      end
  endtask

  task automatic do_req(string rq, bit fill, int tag, bit comp, int size, int perm);
    int w;
    bit eh, ed;
    int ep, es, ec, epm;
    @(negedge clk);
    req_valid = 1; req_fill = fill; req_tag = 16'(tag);
    req_compressed = comp; req_size = 4'(size); req_perm = 2'(perm);
    w = find_way(tag);
    eh = (w >= 0);
    ed = eh && m_res[w];
    ep = eh ? pos_of(w) : 0;
    es = eh ? m_size[w] : 0;
    ec = eh ? int'(m_comp[w]) : 0;
    epm = eh ? m_perm[w] : 0;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", int'(rsp_valid), 1);
    chk(rsp_tag_hit == eh, rq, "tag_hit", int'(rsp_tag_hit), int'(eh));
    chk(rsp_data_hit == ed, rq, "data_hit", int'(rsp_data_hit), int'(ed));
    chk(int'(rsp_stack_pos) == ep, rq, "stack_pos", int'(rsp_stack_pos), ep);
    chk(int'(rsp_size) == es, rq, "size", int'(rsp_size), es);
    chk(int'(rsp_compressed) == ec, rq, "compressed", int'(rsp_compressed), ec);
    chk(int'(rsp_perm) == epm, rq, "perm", int'(rsp_perm), epm);
    if (fill) model_fill(tag, comp, size, perm);
    else if (ed) promote(w);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NT; i++) begin
      m_valid[i] = 0; m_res[i] = 0; m_comp[i] = 0;
      m_size[i] = 0; m_perm[i] = 0; m_tag[i] = 0; m_stack[i] = i;
    end
    void'($urandom(32'd41));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    do_req("R1", 0, 5, 0, 0, 0);
    // 8 + 2 + 6 + 4 = 20 segments: the oldest (uncompressed) loses its data
    do_req("R6", 1, 10, 0, 3, 1);
    do_req("R6", 1, 11, 1, 2, 2);
    do_req("R6", 1, 12, 1, 6, 3);
    do_req("R5", 1, 13, 1, 4, 0);
    do_req("R4", 0, 10, 0, 0, 0);   // tag present, data gone, position 4
    do_req("R4", 0, 10, 0, 0, 0);   // order unchanged
    do_req("R8", 0, 11, 0, 0, 0);   // position 3, promoted
    do_req("R8", 0, 11, 0, 0, 0);   // now position 1
    do_req("R8", 0, 13, 0, 0, 0);   // position 2
    do_req("R7", 1, 20, 0, 0, 1);   // full: replaces least recent tag
    do_req("R7", 0, 10, 0, 0, 0);   // old tag gone
    do_req("R7", 1, 12, 1, 0, 2);   // refill existing tag, size 0 -> 8
    do_req("R6", 0, 12, 0, 0, 0);
    do_req("R5", 0, 20, 0, 0, 0);
    @(negedge clk); req_valid = 0;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R2", "rsp_valid idle", int'(rsp_valid), 0);
    for (int n = 0; n < 3000; n++) begin
      bit f, c;
      int t, s, p;
      f = ($urandom % 2) == 0;
      c = ($urandom % 4) != 0;
      t = 100 + int'($urandom % 7);
      s = int'($urandom % 9);
      p = int'($urandom % 4);
      do_req("R3", f, t, c, s, p);
      if (($urandom % 16) == 0) begin
        @(negedge clk); req_valid = 0;
        @(posedge clk); #1;
        chk(rsp_valid == 1'b0, "R2", "rsp_valid gap", int'(rsp_valid), 0);
      end
    end
    @(negedge clk); req_valid = 0;
    finish_run();
  end
endmodule